// File: doc/BRIEF.md
# Dual-Channel Serial LCD Segment and Backplane Driver

This block is the logic core of a serially loaded liquid-crystal display driver with two independent channels. Each channel holds a shift register that can move data in either direction and a parallel latch behind it. Every latched bit, together with the frame alternation signal, picks one of six external reference levels for its display electrode. The result is a 3-bit level index per output. An analog switch matrix outside this block turns that index into a voltage.

The shift clock, latch clock, alternation signal and serial data arrive from a slow external controller. They are synchronized to a fast system clock and edge-detected. In segment mode both channels shift on the falling shift-clock edge and latch on the falling latch-clock edge. In backplane mode the second channel trades its two clocks, reacts on rising edges, and sees an inverted alternation signal. A single frame-marker bit can then walk along it and drive the common electrodes one row at a time.

Each channel has two serial data pins. They are modelled as separate input, output and output-enable signals. A per-channel direction input chooses which pin receives data and which one passes the far end of the register on to the next device in a chain.

Top module: `lcd_dual_drv`

## Requirements
- R1: Channel 1 shifts by exactly one stage on each falling edge of `sclk_in`. Stage 0 is the left end and drives Y1; stage 19 drives Y20.
- R2: Channel 1 copies its shift register into its latch on each falling edge of `lclk_in`. The latch holds its value at all other times.
- R3: With `ch2_scan` low, channel 2 shifts on falling `sclk_in` and latches on falling `lclk_in`, the same as channel 1. Its stage 0 drives Y21.
- R4: With `ch2_scan` high, channel 2 shifts on rising `lclk_in` and latches on rising `sclk_in`. Falling edges of both clocks have no effect on channel 2.
- R5: With a direction input high, the channel takes data from its right input pin into stage 19 and moves it toward stage 0. Stage 0 appears on the left output, `left_oe`=1 and `right_oe`=0. With the direction input low, data enters stage 0 from the left pin, stage 19 appears on the right output, and the enables are swapped.
- R6: For Y1..Y20 the level index is 1 for a latched 1 with alternation high, 2 for a latched 1 with alternation low, 3 for a latched 0 with alternation high, and 4 for a latched 0 with alternation low.
- R7: For Y21..Y40 with `ch2_scan` low, the index is 1/2 for a latched 1 (alternation high/low) and 5/6 for a latched 0 (alternation high/low).
- R8: For Y21..Y40 with `ch2_scan` high, the alternation is inverted. The index is 2/1 for a latched 1 (alternation high/low) and 6/5 for a latched 0 (alternation high/low).
- R9: Every external input passes two synchronizer flops. An edge takes effect at the third rising `clk` after the input changes, and exactly once. The level outputs follow the latch and the synchronized alternation one cycle later.
- R10: Synchronous active-high `rst` clears both shift registers and latches, so every output selects its unselected level.
- R11: The level index of Y(k) occupies `lvl_out[3k-1:3k-3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External shift clock (asynchronous) |
| lclk_in | input | 1 | External latch clock (asynchronous) |
| alt_in | input | 1 | Frame alternation signal (asynchronous) |
| ch2_scan | input | 1 | Channel 2 backplane mode select |
| dir1 | input | 1 | Channel 1 shift direction |
| dir2 | input | 1 | Channel 2 shift direction |
| ch1_left_in | input | 1 | Channel 1 left serial pin, input side |
| ch1_right_in | input | 1 | Channel 1 right serial pin, input side |
| ch1_left_out | output | 1 | Channel 1 left serial pin, output side |
| ch1_right_out | output | 1 | Channel 1 right serial pin, output side |
| ch1_left_oe | output | 1 | Channel 1 left pin drive enable |
| ch1_right_oe | output | 1 | Channel 1 right pin drive enable |
| ch2_left_in | input | 1 | Channel 2 left serial pin, input side |
| ch2_right_in | input | 1 | Channel 2 right serial pin, input side |
| ch2_left_out | output | 1 | Channel 2 left serial pin, output side |
| ch2_right_out | output | 1 | Channel 2 right serial pin, output side |
| ch2_left_oe | output | 1 | Channel 2 left pin drive enable |
| ch2_right_oe | output | 1 | Channel 2 right pin drive enable |
| lvl_out | output | 120 | Packed 3-bit level index per output, Y1 in the low bits |

## Verification
The bench loads both channels in both directions while the unused data pin carries the complement of the real bit. A design that read the wrong pin, or shifted the wrong way, then produces inverted or mirrored latch contents. In backplane mode, one pulse on each clock gives channel 2 both a falling and a rising edge. A design that kept falling-edge sensitivity there, or forgot to invert the alternation, shifts the marker twice or shows indices 1/5 where 2/6 belong. Alternation toggles and a reset in the middle of the run expose an off-by-one synchronizer latency, a doubled edge action, or outputs that fail to return to the unselected level.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int LVW = 3;
  typedef logic [LVW-1:0] lvl_t;

  localparam lvl_t LV1 = 3'd1;
  localparam lvl_t LV2 = 3'd2;
  localparam lvl_t LV3 = 3'd3;
  localparam lvl_t LV4 = 3'd4;
  localparam lvl_t LV5 = 3'd5;
  localparam lvl_t LV6 = 3'd6;
endpackage

// File: rtl/lcd_sync2.sv
module lcd_sync2 #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/lcd_shift_chan.sv
module lcd_shift_chan #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir,
  input  logic         shift_en,
  input  logic         latch_en,
  input  logic         left_in,
  input  logic         right_in,
  output logic         left_out,
  output logic         right_out,
  output logic         left_oe,
  output logic         right_oe,
  output logic [N-1:0] latched
);
  logic [N-1:0] sr, sr_next;

  always_comb begin
    if (dir) sr_next = {right_in, sr[N-1:1]};
    else     sr_next = {sr[N-2:0], left_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      latched <= '0;
    end else begin
      if (shift_en) sr      <= sr_next;
      if (latch_en) latched <= sr;
    end
  end

  assign left_out  = sr[0];
  assign right_out = sr[N-1];
  assign left_oe   = dir;
  assign right_oe  = ~dir;
endmodule

// File: rtl/lcd_level_dec.sv
module lcd_level_dec
  import lcd_drv_pkg::*;
#(
  parameter int   N      = 20,
  parameter lvl_t SEL_HI = LV1,
  parameter lvl_t SEL_LO = LV2,
  parameter lvl_t UNS_HI = LV3,
  parameter lvl_t UNS_LO = LV4
) (
  input  logic           clk,
  input  logic [N-1:0]   bits,
  input  logic           m,
  output logic [N*LVW-1:0] codes
);
  for (genvar i = 0; i < N; i++) begin : g_pix
    always_ff @(posedge clk) begin
      if (bits[i]) codes[i*LVW +: LVW] <= m ? SEL_HI : SEL_LO;
      else         codes[i*LVW +: LVW] <= m ? UNS_HI : UNS_LO;
    end
  end
endmodule

// File: rtl/lcd_dual_drv.sv
module lcd_dual_drv
  import lcd_drv_pkg::*;
#(
  parameter int STAGES      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sclk_in,
  input  logic                      lclk_in,
  input  logic                      alt_in,
  input  logic                      ch2_scan,
  input  logic                      dir1,
  input  logic                      dir2,
  input  logic                      ch1_left_in,
  input  logic                      ch1_right_in,
  output logic                      ch1_left_out,
  output logic                      ch1_right_out,
  output logic                      ch1_left_oe,
  output logic                      ch1_right_oe,
  input  logic                      ch2_left_in,
  input  logic                      ch2_right_in,
  output logic                      ch2_left_out,
  output logic                      ch2_right_out,
  output logic                      ch2_left_oe,
  output logic                      ch2_right_oe,
  output logic [2*STAGES*LVW-1:0]   lvl_out
);
  localparam int NIN = 7;
  localparam int CHW = STAGES * LVW;

  logic [NIN-1:0] raw_in, syn;
  logic sclk_s, lclk_s, alt_s;
  logic c1l_s, c1r_s, c2l_s, c2r_s;
  logic sclk_q, lclk_q;
  logic sclk_fall, sclk_rise, lclk_fall, lclk_rise;
  logic sh_en1, lat_en1, sh_en2, lat_en2;
  logic alt2;
  logic [STAGES-1:0] ch1_lat, ch2_lat;

  assign raw_in = {sclk_in, lclk_in, alt_in, ch1_left_in, ch1_right_in,
                   ch2_left_in, ch2_right_in};

  lcd_sync2 #(.W(NIN), .DEPTH(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (syn)
  );

  assign {sclk_s, lclk_s, alt_s, c1l_s, c1r_s, c2l_s, c2r_s} = syn;

  always_ff @(posedge clk) begin
    sclk_q <= sclk_s;
    lclk_q <= lclk_s;
  end

  assign sclk_fall = sclk_q & ~sclk_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign lclk_fall = lclk_q & ~lclk_s;
  assign lclk_rise = ~lclk_q & lclk_s;

  assign sh_en1  = sclk_fall;
  assign lat_en1 = lclk_fall;
  assign sh_en2  = ch2_scan ? lclk_rise : sclk_fall;
  assign lat_en2 = ch2_scan ? sclk_rise : lclk_fall;
  assign alt2    = alt_s ^ ch2_scan;

  lcd_shift_chan #(.N(STAGES)) u_ch1 (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir1),
    .shift_en  (sh_en1),
    .latch_en  (lat_en1),
    .left_in   (c1l_s),
    .right_in  (c1r_s),
    .left_out  (ch1_left_out),
    .right_out (ch1_right_out),
    .left_oe   (ch1_left_oe),
    .right_oe  (ch1_right_oe),
    .latched   (ch1_lat)
  );

  lcd_shift_chan #(.N(STAGES)) u_ch2 (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir2),
    .shift_en  (sh_en2),
    .latch_en  (lat_en2),
    .left_in   (c2l_s),
    .right_in  (c2r_s),
    .left_out  (ch2_left_out),
    .right_out (ch2_right_out),
    .left_oe   (ch2_left_oe),
    .right_oe  (ch2_right_oe),
    .latched   (ch2_lat)
  );

  lcd_level_dec #(
    .N(STAGES), .SEL_HI(LV1), .SEL_LO(LV2), .UNS_HI(LV3), .UNS_LO(LV4)
  ) u_dec1 (
    .clk   (clk),
    .bits  (ch1_lat),
    .m     (alt_s),
    .codes (lvl_out[CHW-1:0])
  );

  lcd_level_dec #(
    .N(STAGES), .SEL_HI(LV1), .SEL_LO(LV2), .UNS_HI(LV5), .UNS_LO(LV6)
  ) u_dec2 (
    .clk   (clk),
    .bits  (ch2_lat),
    .m     (alt2),
    .codes (lvl_out[2*CHW-1:CHW])
  );
endmodule

// File: rtl/lcd_dual_drv_chk.sv
module lcd_dual_drv_chk #(
  parameter int STAGES = 20
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  dir1,
  input logic                  dir2,
  input logic                  ch2_scan,
  input logic                  ch1_left_oe,
  input logic                  ch1_right_oe,
  input logic                  ch2_left_oe,
  input logic                  ch2_right_oe,
  input logic                  lat_en1,
  input logic                  lat_en2,
  input logic [STAGES-1:0]     ch1_lat,
  input logic [STAGES-1:0]     ch2_lat,
  input logic [2*STAGES*3-1:0] lvl_out
);
  // R5
  oe1_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (ch1_left_oe == dir1) && (ch1_right_oe == !dir1));

  // R5
  oe2_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (ch2_left_oe == dir2) && (ch2_right_oe == !dir2));

  // R2
  ch1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(lat_en1) && !$past(rst)) |-> $stable(ch1_lat));

  // R4
  ch2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(lat_en2) && !$past(rst)) |-> $stable(ch2_lat));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ch1_lat == '0 && ch2_lat == '0));

  for (genvar k = 0; k < STAGES; k++) begin : g_pix
    // R6
    ch1_sel_chk: assert property (@(posedge clk) disable iff (rst)
      $past(ch1_lat[k]) |-> (lvl_out[3*k +: 3] == 3'd1 || lvl_out[3*k +: 3] == 3'd2));
    // R6
    ch1_uns_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(ch1_lat[k]) |-> (lvl_out[3*k +: 3] == 3'd3 || lvl_out[3*k +: 3] == 3'd4));
    // R7 R8
    ch2_sel_chk: assert property (@(posedge clk) disable iff (rst)
      $past(ch2_lat[k]) |->
        (lvl_out[3*(STAGES+k) +: 3] == 3'd1 || lvl_out[3*(STAGES+k) +: 3] == 3'd2));
    // R7 R8
    ch2_uns_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(ch2_lat[k]) |->
        (lvl_out[3*(STAGES+k) +: 3] == 3'd5 || lvl_out[3*(STAGES+k) +: 3] == 3'd6));
  end
endmodule

bind lcd_dual_drv lcd_dual_drv_chk #(.STAGES(STAGES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dir1         (dir1),
  .dir2         (dir2),
  .ch2_scan     (ch2_scan),
  .ch1_left_oe  (ch1_left_oe),
  .ch1_right_oe (ch1_right_oe),
  .ch2_left_oe  (ch2_left_oe),
  .ch2_right_oe (ch2_right_oe),
  .lat_en1      (lat_en1),
  .lat_en2      (lat_en2),
  .ch1_lat      (ch1_lat),
  .ch2_lat      (ch2_lat),
  .lvl_out      (lvl_out)
);

// File: tb/lcd_dual_drv_test.sv
`timescale 1ns/1ps
module lcd_dual_drv_test;
  localparam int N = 20;

  logic clk = 0;
  logic rst = 1;
  logic sclk_in = 1, lclk_in = 1, alt_in = 0, ch2_scan = 0;
  logic dir1 = 1, dir2 = 0;
  logic ch1_left_in = 0, ch1_right_in = 0, ch2_left_in = 0, ch2_right_in = 0;
  logic ch1_left_out, ch1_right_out, ch1_left_oe, ch1_right_oe;
  logic ch2_left_out, ch2_right_out, ch2_left_oe, ch2_right_oe;
  logic [2*N*3-1:0] lvl_out;

  int checks = 0, fails = 0;
  bit checking = 0, done = 0;

  always #2.5 clk = ~clk;

  lcd_dual_drv uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .lclk_in(lclk_in), .alt_in(alt_in),
    .ch2_scan(ch2_scan), .dir1(dir1), .dir2(dir2),
    .ch1_left_in(ch1_left_in), .ch1_right_in(ch1_right_in),
    .ch1_left_out(ch1_left_out), .ch1_right_out(ch1_right_out),
    .ch1_left_oe(ch1_left_oe), .ch1_right_oe(ch1_right_oe),
    .ch2_left_in(ch2_left_in), .ch2_right_in(ch2_right_in),
    .ch2_left_out(ch2_left_out), .ch2_right_out(ch2_right_out),
    .ch2_left_oe(ch2_left_oe), .ch2_right_oe(ch2_right_oe),
    .lvl_out(lvl_out)
  );

  // Behavioural reference: input history queue and per-channel bit arrays
  logic [6:0] hist[$];
  bit msr  [2][N];
  bit mlat [2][N];
  int exp_lvl [2*N];

  function automatic int level_of(int ch, bit b, bit m, bit scan);
    bit mm;
    if (ch == 0) return b ? (m ? 1 : 2) : (m ? 3 : 4);
    mm = scan ? !m : m;
    return b ? (mm ? 1 : 2) : (mm ? 5 : 6);
  endfunction

  initial hist = '{7'd0, 7'd0, 7'd0, 7'd0};

  always @(posedge clk) begin
    logic [6:0] cur, old;
    bit sh[2], la[2], dirs[2], din[2];
    bit nxt[N];
    hist.push_front({sclk_in, lclk_in, alt_in, ch1_left_in, ch1_right_in,
                     ch2_left_in, ch2_right_in});
    if (hist.size() > 4) void'(hist.pop_back());
    cur = hist[2];
    old = hist[3];
    for (int k = 0; k < N; k++) begin
      exp_lvl[k]     = level_of(0, mlat[0][k], cur[4], ch2_scan);
      exp_lvl[N + k] = level_of(1, mlat[1][k], cur[4], ch2_scan);
    end
    if (rst) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < N; k++) begin msr[c][k] = 0; mlat[c][k] = 0; end
    end else begin
      sh[0] = old[6] && !cur[6];
      la[0] = old[5] && !cur[5];
      sh[1] = ch2_scan ? (!old[5] && cur[5]) : sh[0];
      la[1] = ch2_scan ? (!old[6] && cur[6]) : la[0];
      dirs[0] = dir1; dirs[1] = dir2;
      din[0] = dir1 ? cur[2] : cur[3];
      din[1] = dir2 ? cur[0] : cur[1];
      for (int c = 0; c < 2; c++) begin
        if (la[c]) for (int k = 0; k < N; k++) mlat[c][k] = msr[c][k];
        if (sh[c]) begin
          for (int k = 0; k < N; k++) begin
            if (dirs[c]) nxt[k] = (k == N-1) ? din[c] : msr[c][k+1];
            else         nxt[k] = (k == 0)   ? din[c] : msr[c][k-1];
          end
          for (int k = 0; k < N; k++) msr[c][k] = nxt[k];
        end
      end
    end
  end

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      for (int k = 0; k < 2*N; k++) begin
        int got;
        got = int'(lvl_out[3*k +: 3]);
        checks++;
        if (got != exp_lvl[k]) begin
          fails++;
          $display("FAIL %s Y%0d at %0t: got %0d expected %0d",
                   (k < N) ? "R6 R2 R11" : (ch2_scan ? "R8 R4 R11" : "R7 R3 R11"),
                   k + 1, $time, got, exp_lvl[k]);
        end
      end
      if (dir1) check_bit("R1 R9 ch1 left out", ch1_left_out, msr[0][0]);
      else      check_bit("R1 R9 ch1 right out", ch1_right_out, msr[0][N-1]);
      if (dir2) check_bit(ch2_scan ? "R4 R9 ch2 left out" : "R3 R9 ch2 left out",
                          ch2_left_out, msr[1][0]);
      else      check_bit(ch2_scan ? "R4 R9 ch2 right out" : "R3 R9 ch2 right out",
                          ch2_right_out, msr[1][N-1]);
      check_bit("R5 ch1 left oe", ch1_left_oe, dir1);
      check_bit("R5 ch1 right oe", ch1_right_oe, !dir1);
      check_bit("R5 ch2 left oe", ch2_left_oe, dir2);
      check_bit("R5 ch2 right oe", ch2_right_oe, !dir2);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Real bit on the active input pin, its complement on the ignored one
  task automatic put_data(bit b1, bit b2);
    ch1_right_in = dir1 ? b1 : !b1;
    ch1_left_in  = dir1 ? !b1 : b1;
    ch2_right_in = dir2 ? b2 : !b2;
    ch2_left_in  = dir2 ? !b2 : b2;
  endtask

  task automatic pulse_sclk();
    sclk_in = 0; wait_clk(4); sclk_in = 1; wait_clk(4);
  endtask

  task automatic pulse_lclk();
    lclk_in = 0; wait_clk(4); lclk_in = 1; wait_clk(4);
  endtask

  task automatic load(int seed);
    for (int i = 0; i < N; i++) begin
      put_data(((i + seed) % 3) == 0, ((i * seed) % 5) < 2);
      wait_clk(3);
      pulse_sclk();
    end
    pulse_lclk();
  endtask

  task automatic toggle_alt(int times);
    for (int i = 0; i < times; i++) begin
      alt_in = !alt_in; wait_clk(5);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    wait_clk(6);
    rst = 0;
    wait_clk(1);
    checking = 1;
    // R10: after reset every output is unselected (alternation low)
    wait_clk(2);
    for (int k = 0; k < 2*N; k++) begin
      checks++;
      if (int'(lvl_out[3*k +: 3]) != ((k < N) ? 4 : 6)) begin
        fails++;
        $display("FAIL R10 Y%0d: got %0d expected %0d", k + 1,
                 lvl_out[3*k +: 3], (k < N) ? 4 : 6);
      end
    end
    // Segment mode, both directions
    alt_in = 1; dir1 = 1; dir2 = 0;
    load(1);
    toggle_alt(3);
    dir1 = 0; dir2 = 1;
    load(2);
    toggle_alt(2);
    // Backplane mode: walk a frame marker along channel 2
    ch2_scan = 1; dir2 = 0;
    wait_clk(4);
    for (int r = 0; r < 8; r++) begin
      put_data(r[0], r == 0);
      wait_clk(3);
      pulse_lclk();
      pulse_sclk();
      toggle_alt(2);
    end
    dir2 = 1;
    for (int r = 0; r < 4; r++) begin
      put_data(!r[0], r == 1);
      wait_clk(3);
      pulse_lclk();
      pulse_sclk();
      toggle_alt(1);
    end
    // Reset in the middle of the run
    rst = 1; wait_clk(3); rst = 0;
    wait_clk(6);
    ch2_scan = 0;
    load(3);
    toggle_alt(2);
    wait_clk(10);
    checking = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule